// File: doc/BRIEF.md
# Command Buffer Fetch Sequencer

This block walks a buffer of 64-bit command words on behalf of one execution thread. Software loads a start PC and an end address and starts the thread. The sequencer then reads one word at a time through a simple read port. It stops and pulses `done_o` when the PC reaches the end address. Ordinary commands are treated as no-ops and the PC moves past them. Two jump forms redirect the PC: one to an absolute address and one by a signed byte offset. A bad command word, or an address outside the memory, halts the thread and sets a sticky error flag.

PC, end and jump-target values are held in a stored form. The byte address is the stored value shifted left by 0 or by 3, chosen at start. Software can hold the thread with a suspend input. While the thread is held, it can rewrite the PC and the end address. When the hold is released, execution continues from the new PC and stops at the new end.

Top module: `cmd_fetch_seq`

## Requirements
- R1: After reset, `busy_o`, `suspended_o`, `done_o`, `error_o` and `mem_req_o` are all 0.
- R2: `start_i` is accepted only while the block is idle. It loads PC and end from `start_pc_i`/`start_end_i`, samples `shift_en_i`, and sets `busy_o`. A start pulse while busy has no effect on the running program.
- R3: A word whose upper-half opcode (bits 63:56) is below 0x10 is a no-op. It advances the PC by 8 bytes, which is +8 stored with shift 0 and +1 stored with shift 3. Each fetch costs two cycles.
- R4: When PC equals the end address, the block emits a `done_o` pulse of exactly one cycle and clears `busy_o`. This happens without any fetch if PC already equals end at start.
- R5: A word whose upper half (bits 63:32) is 0x10000001 sets PC to its lower half (bits 31:0), taken in stored form.
- R6: A word whose upper half is 0x10000000 adds its lower half to the current byte address as a signed byte offset. Backward jumps are supported.
- R7: With `shift_en_i`=1 at start, the fetch byte address `mem_addr_o` is the stored PC times 8. With 0, it is the stored PC itself.
- R8: While `suspend_i` is high, the block finishes any fetch already in flight, then holds with `suspended_o`=1. During the hold it issues no `mem_req_o` and keeps the PC unchanged.
- R9: While suspended, `wr_pc_i`/`wr_end_i` replace PC/end. After release, execution runs from the new PC to the new end.
- R10: `wr_pc_i`/`wr_end_i` are ignored unless the block is suspended.
- R11: An upper half that is neither jump form and has opcode 0x10 or higher sets `error_o`, clears `busy_o` and gives no `done_o`. PC stays at the faulting word. The next accepted start clears `error_o`.
- R12: A jump target or fetch address whose byte address is at or beyond 2^MEM_AW raises the error as in R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| shift_en_i | input | 1 | Address shift select (1 = shift by 3), sampled at start |
| start_pc_i | input | 32 | Stored-form start PC |
| start_end_i | input | 32 | Stored-form end address |
| suspend_i | input | 1 | Hold request |
| wr_pc_i | input | 1 | PC rewrite strobe (effective while suspended) |
| wr_pc_data_i | input | 32 | New stored PC |
| wr_end_i | input | 1 | End rewrite strobe (effective while suspended) |
| wr_end_data_i | input | 32 | New stored end address |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | MEM_AW | Byte address of the word to read |
| mem_rdata_i | input | 64 | Read data, valid the cycle after the request |
| busy_o | output | 1 | Thread enabled |
| suspended_o | output | 1 | Thread held |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Sticky fault flag |
| pc_o | output | 32 | Current stored PC |
| end_o | output | 32 | Current stored end address |

## Verification
Straight runs of no-ops are tried with both shift settings. Comparing fetch counts and final PCs between the two separates stored-unit arithmetic from byte arithmetic. Absolute jumps are tried in both modes, and relative jumps both forward and backward; a sign or scaling fault in the offset path lands on a different final PC or changes the fetch count. A start with PC already equal to end isolates the end check from fetching. Faulting words are tried separately to tell the opcode checks from the range check: a bad opcode, a bad jump subcode, and an out-of-range absolute target. Start and rewrite strobes during a run, and a suspended start followed by a retarget, show whether rewrites are gated by the suspend state.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  localparam int WORD_W = 64;
  localparam int HALF_W = 32;
  localparam int BYTE_W = HALF_W + 3;
  localparam logic [HALF_W-1:0] JUMP_ABS_HI = 32'h1000_0001;
  localparam logic [HALF_W-1:0] JUMP_REL_HI = 32'h1000_0000;
  localparam logic [7:0]        OP_JUMP     = 8'h10;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WAIT, ST_SUSP} st_e;
  typedef enum logic [1:0] {K_NOP, K_JABS, K_JREL, K_BAD} kind_e;

  // stored form -> byte address
  function automatic logic [BYTE_W-1:0] byte_addr(logic [HALF_W-1:0] pc, logic sh);
    return sh ? {pc, 3'b000} : {3'b000, pc};
  endfunction

  // stored increment for one 8-byte instruction
  function automatic logic [HALF_W-1:0] step(logic sh);
    return sh ? 32'd1 : 32'd8;
  endfunction

  // signed byte offset applied in stored units
  function automatic logic [HALF_W-1:0] rel_target(logic [HALF_W-1:0] pc,
                                                   logic [HALF_W-1:0] off, logic sh);
    logic signed [HALF_W-1:0] soff;
    soff = $signed(off);
    return sh ? pc + HALF_W'(soff >>> 3) : pc + off;
  endfunction

  function automatic logic out_of_range(logic [HALF_W-1:0] pc, logic sh, int aw);
    logic [BYTE_W-1:0] b;
    b = byte_addr(pc, sh);
    return (b >> aw) != '0;
  endfunction
endpackage

// File: rtl/cfs_decode.sv
module cfs_decode import cfs_pkg::*; #(
  parameter int MEM_AW = 10
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [HALF_W-1:0] pc_i,
  input  logic              shift_i,
  output logic [HALF_W-1:0] next_pc_o,
  output logic              fault_o
);
  logic [HALF_W-1:0] hi, lo;
  kind_e kind;

  always_comb begin
    hi = word_i[WORD_W-1:HALF_W];
    lo = word_i[HALF_W-1:0];
    if (hi == JUMP_ABS_HI) begin
      kind      = K_JABS;
      next_pc_o = lo;
    end else if (hi == JUMP_REL_HI) begin
      kind      = K_JREL;
      next_pc_o = rel_target(pc_i, lo, shift_i);
    end else if (hi[HALF_W-1 -: 8] < OP_JUMP) begin
      kind      = K_NOP;
      next_pc_o = pc_i + step(shift_i);
    end else begin
      kind      = K_BAD;
      next_pc_o = pc_i;
    end
    fault_o = (kind == K_BAD) ||
              ((kind == K_JABS || kind == K_JREL) && out_of_range(next_pc_o, shift_i, MEM_AW));
  end
endmodule

// File: rtl/cfs_addr_regs.sv
module cfs_addr_regs #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_pc_i,
  input  logic [AW-1:0] load_end_i,
  input  logic          wr_pc_i,
  input  logic [AW-1:0] wr_pc_data_i,
  input  logic          wr_end_i,
  input  logic [AW-1:0] wr_end_data_i,
  input  logic          adv_i,
  input  logic [AW-1:0] adv_pc_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] end_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_o  <= '0;
      end_o <= '0;
    end else if (load_i) begin
      pc_o  <= load_pc_i;
      end_o <= load_end_i;
    end else begin
      if (wr_pc_i)     pc_o  <= wr_pc_data_i;
      else if (adv_i)  pc_o  <= adv_pc_i;
      if (wr_end_i)    end_o <= wr_end_data_i;
    end
  end
endmodule

// File: rtl/cmd_fetch_seq.sv
module cmd_fetch_seq import cfs_pkg::*; #(
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              shift_en_i,
  input  logic [31:0]       start_pc_i,
  input  logic [31:0]       start_end_i,
  input  logic              suspend_i,
  input  logic              wr_pc_i,
  input  logic [31:0]       wr_pc_data_i,
  input  logic              wr_end_i,
  input  logic [31:0]       wr_end_data_i,
  output logic              mem_req_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  input  logic [63:0]       mem_rdata_i,
  output logic              busy_o,
  output logic              suspended_o,
  output logic              done_o,
  output logic              error_o,
  output logic [31:0]       pc_o,
  output logic [31:0]       end_o
);
  st_e st_q, st_d;
  logic              sh_q, done_q, err_q;
  logic [HALF_W-1:0] pc_q, end_q, dec_next;
  logic [BYTE_W-1:0] fetch_byte;
  logic dec_fault, at_end, fetch_oob;
  // named events
  logic start_acc, finish_ev, fetch_go, fetch_bad, dec_bad, adv_ev, sw_wr_ok;

  always_comb begin
    at_end     = (pc_q == end_q);
    fetch_byte = byte_addr(pc_q, sh_q);
    fetch_oob  = |fetch_byte[BYTE_W-1:MEM_AW];
    start_acc  = (st_q == ST_IDLE) && start_i;
    finish_ev  = (st_q == ST_RUN) && at_end;
    fetch_go   = (st_q == ST_RUN) && !at_end && !suspend_i && !fetch_oob;
    fetch_bad  = (st_q == ST_RUN) && !at_end && !suspend_i && fetch_oob;
    dec_bad    = (st_q == ST_WAIT) && dec_fault;
    adv_ev     = (st_q == ST_WAIT) && !dec_fault;
    sw_wr_ok   = (st_q == ST_SUSP);
  end

  cfs_decode #(.MEM_AW(MEM_AW)) u_dec (
    .word_i   (mem_rdata_i),
    .pc_i     (pc_q),
    .shift_i  (sh_q),
    .next_pc_o(dec_next),
    .fault_o  (dec_fault)
  );

  cfs_addr_regs #(.AW(HALF_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (start_acc),
    .load_pc_i    (start_pc_i),
    .load_end_i   (start_end_i),
    .wr_pc_i      (wr_pc_i && sw_wr_ok),
    .wr_pc_data_i (wr_pc_data_i),
    .wr_end_i     (wr_end_i && sw_wr_ok),
    .wr_end_data_i(wr_end_data_i),
    .adv_i        (adv_ev),
    .adv_pc_i     (dec_next),
    .pc_o         (pc_q),
    .end_o        (end_q)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_RUN;
      ST_RUN: begin
        if (at_end)         st_d = ST_IDLE;
        else if (suspend_i) st_d = ST_SUSP;
        else if (fetch_oob) st_d = ST_IDLE;
        else                st_d = ST_WAIT;
      end
      ST_WAIT: st_d = dec_fault ? ST_IDLE : ST_RUN;
      ST_SUSP: if (!suspend_i) st_d = ST_RUN;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sh_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= finish_ev;
      if (start_acc) begin
        sh_q  <= shift_en_i;
        err_q <= 1'b0;
      end else if (fetch_bad || dec_bad) begin
        err_q <= 1'b1;
      end
    end
  end

  assign mem_req_o   = fetch_go;
  assign mem_addr_o  = fetch_byte[MEM_AW-1:0];
  assign busy_o      = (st_q != ST_IDLE);
  assign suspended_o = (st_q == ST_SUSP);
  assign done_o      = done_q;
  assign error_o     = err_q;
  assign pc_o        = pc_q;
  assign end_o       = end_q;

  // ---------------- assertions ----------------
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!done_o && !error_o && !busy_o));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && pc_o == end_o));

  assert_no_fetch_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    suspended_o |-> !mem_req_o);

  assert_held_pc_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended_o && !wr_pc_i) |=> (pc_o == $past(pc_o)));

  assert_err_halts_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error_o) |-> (!busy_o && !done_o));

  assert_req_in_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (busy_o && !out_of_range(pc_o, sh_q, MEM_AW)));
endmodule

// File: tb/cmd_fetch_seq_tb.sv
module cmd_fetch_seq_tb;
  localparam int MEM_AW = 10;
  localparam int NW     = 1 << (MEM_AW - 3);
  localparam int NV     = 11;
  // {shift, pc, end, exp_pc, exp_err, exp_fetches}
  localparam logic [105:0] VEC [NV] = '{
    {1'b0, 32'h008, 32'h028, 32'h028, 1'b0, 8'd4},  // R3 no-ops, shift 0
    {1'b1, 32'h001, 32'h005, 32'h005, 1'b0, 8'd4},  // R7 no-ops, shift 3
    {1'b0, 32'h090, 32'h110, 32'h110, 1'b0, 8'd5},  // R5 abs jump
    {1'b1, 32'h026, 32'h032, 32'h032, 1'b0, 8'd5},  // R5 abs jump, shift 3
    {1'b0, 32'h1D0, 32'h230, 32'h230, 1'b0, 8'd5},  // R6 forward rel jump
    {1'b1, 32'h053, 32'h052, 32'h052, 1'b0, 8'd2},  // R6 backward rel jump
    {1'b0, 32'h028, 32'h028, 32'h028, 1'b0, 8'd0},  // R4 start at end
    {1'b0, 32'h318, 32'h3F8, 32'h320, 1'b1, 8'd2},  // R11 bad opcode
    {1'b1, 32'h067, 32'h07F, 32'h068, 1'b1, 8'd2},  // R11 bad jump subcode
    {1'b0, 32'h368, 32'h3F8, 32'h370, 1'b1, 8'd2},  // R12 target out of range
    {1'b1, 32'h06D, 32'h07F, 32'h06E, 1'b1, 8'd2}   // R12 out of range, shift 3
  };
  string tags [NV] = '{"R3","R7","R5","R5","R6","R6","R4","R11","R11","R12","R12"};

  logic clk = 0, rst_n = 0;
  logic start_i = 0, shift_en_i = 0, suspend_i = 0, wr_pc_i = 0, wr_end_i = 0;
  logic [31:0] start_pc_i = 0, start_end_i = 0, wr_pc_data_i = 0, wr_end_data_i = 0;
  logic mem_req_o, busy_o, suspended_o, done_o, error_o;
  logic [MEM_AW-1:0] mem_addr_o;
  logic [63:0] mem_rdata_i = 0;
  logic [31:0] pc_o, end_o;
  logic [63:0] mem [NW];
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  cmd_fetch_seq #(.MEM_AW(MEM_AW)) u_dut (.*);

  always @(posedge clk) if (mem_req_o) mem_rdata_i <= mem[mem_addr_o[MEM_AW-1:3]];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic sh, input logic [31:0] pc, input logic [31:0] en,
                     input bit disturb, output logic [31:0] fpc, output logic ferr,
                     output int nf, output int nd);
    int cyc;
    @(negedge clk);
    shift_en_i = sh; start_pc_i = pc; start_end_i = en; start_i = 1;
    @(negedge clk);
    start_i = 0; nf = 0; nd = 0; cyc = 0;
    while (busy_o && cyc < 4000) begin
      if (mem_req_o) nf++;
      if (disturb && cyc == 6) begin
        start_i = 1; start_pc_i = 32'h1D0; start_end_i = 32'h230;
        wr_pc_i = 1; wr_pc_data_i = 32'h300; wr_end_i = 1; wr_end_data_i = 32'h300;
      end else begin
        start_i = 0; wr_pc_i = 0; wr_end_i = 0;
      end
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 4000) chk("watchdog-run", 32'd1, 32'd0);
    nd = int'(done_o);
    fpc = pc_o; ferr = error_o;
    @(negedge clk);
    nd += int'(done_o);
  endtask

  initial begin
    logic [31:0] fpc;
    logic ferr;
    int nf, nd;
    for (int w = 0; w < NW; w++) mem[w] = {8'h01, 24'(w), 32'(w)};
    mem[20]  = {32'h1000_0001, 32'h0000_0100};
    mem[40]  = {32'h1000_0001, 32'h0000_0030};
    mem[60]  = {32'h1000_0000, 32'h0000_0040};
    mem[84]  = {32'h1000_0000, 32'hFFFF_FFF0};
    mem[100] = {32'h2000_0000, 32'h0};
    mem[104] = {32'h1000_0002, 32'h0};
    mem[110] = {32'h1000_0001, 32'h0000_1000};

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 busy", 32'(busy_o), 0);
    chk("R1 done", 32'(done_o), 0);
    chk("R1 error", 32'(error_o), 0);
    chk("R1 req", 32'(mem_req_o), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 suspended", 32'(suspended_o), 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      run(VEC[i][105], VEC[i][104:73], VEC[i][72:41], 1'b0, fpc, ferr, nf, nd);
      chk({tags[i], " pc"}, fpc, VEC[i][40:9]);
      chk({tags[i], " error"}, 32'(ferr), 32'(VEC[i][8]));
      chk({tags[i], " fetches"}, 32'(nf), 32'(VEC[i][7:0]));
      chk({tags[i], " done count"}, 32'(nd), VEC[i][8] ? 0 : 1);
    end

    // R11: error left from last vector is cleared by the next start
    chk("R11 sticky", 32'(error_o), 1);
    @(negedge clk);
    shift_en_i = 0; start_pc_i = 32'h008; start_end_i = 32'h010; start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk("R11 cleared by start", 32'(error_o), 0);
    repeat (6) @(negedge clk);

    // R2 and R10: start and rewrites during a run are ignored
    run(1'b0, 32'h380, 32'h3F0, 1'b1, fpc, ferr, nf, nd);
    wr_pc_i = 0; wr_end_i = 0; start_i = 0;
    chk("R2 R10 pc", fpc, 32'h3F0);
    chk("R2 R10 fetches", 32'(nf), 14);
    chk("R10 end kept", end_o, 32'h3F0);

    // R8 and R9: hold from start, retarget, resume
    @(negedge clk);
    suspend_i = 1; shift_en_i = 0; start_pc_i = 32'h380; start_end_i = 32'h3F0; start_i = 1;
    @(negedge clk);
    start_i = 0;
    nf = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (mem_req_o) nf++;
    end
    chk("R8 suspended", 32'(suspended_o), 1);
    chk("R8 no fetch", 32'(nf), 0);
    chk("R8 pc held", pc_o, 32'h380);
    wr_pc_i = 1; wr_pc_data_i = 32'h1D0; wr_end_i = 1; wr_end_data_i = 32'h230;
    @(negedge clk);
    wr_pc_i = 0; wr_end_i = 0;
    chk("R9 pc written", pc_o, 32'h1D0);
    chk("R9 end written", end_o, 32'h230);
    suspend_i = 0;
    nf = 0; nd = 0;
    for (int k = 0; k < 400 && busy_o; k++) begin
      @(negedge clk);
      if (mem_req_o) nf++;
    end
    chk("R9 resumed fetches", 32'(nf), 5);
    chk("R9 resumed pc", pc_o, 32'h230);
    chk("R4 done after resume", 32'(done_o), 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule